// File: doc/BRIEF.md
# Fractional-N Tick Divider

This block turns a slow reference clock into a periodic one-cycle tick whose average spacing is a non-integer number of reference cycles. A 22-bit control word carries an integer divisor N, a fraction F, a window select, an enable and a reset-request level for a downstream timekeeper. Each output period lasts either N or N+1 reference cycles. Over any run of D consecutive periods, exactly F periods take the longer length, where D is 1000 or 1024. The average ratio is therefore N + F/D. The default word gives N=327, F=680 and D=1000, which turns a 32768 Hz reference into a 100 Hz tick.

The long periods are spread evenly by a phase accumulator. Configuration is copied into a shadow register only at a period boundary, so a running period is never cut short. Clearing the enable stops the tick within one cycle and returns the divider to a known phase. The reset-request bit does not pass through the divider; it is registered and driven out.

Top module: `frac_tick_div`

## Requirements
- R1: The control word fields are: fraction F in bits [9:0], integer divisor N in bits [18:10], window select in bit 19 (0 selects D=1000, 1 selects D=1024), enable in bit 20 (1 = run), and reset request in bit 21.
- R2: `tick` is high for exactly one reference cycle, on the last cycle of each period. Each period lasts N or N+1 cycles.
- R3: The first period after enabling lasts N cycles. Period k (k ≥ 1) lasts N+1 cycles exactly when floor(k·F/D) > floor((k−1)·F/D). Periods 1 through D therefore contain exactly F long periods.
- R4: When F ≥ D, the divider behaves as if F were D−1.
- R5: When N is 0 or 1, no tick is produced.
- R6: When the enable bit is sampled low, `tick` is low from the next cycle on. Re-enabling restarts at zero phase, so the period sequence is the one given by R3.
- R7: A control word change takes effect at the next period boundary. The period in progress completes with its old length.
- R8: `tk_reset_req` equals bit 21 of the control word as sampled at the previous clock edge, whether or not the divider is enabled.
- R9: After synchronous reset, `tick` and `tk_reset_req` are low. The shadow configuration holds the default word 335528 (N=327, F=680, D=1000, disabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 22 | Control word (fields per R1) |
| tick | output | 1 | One-cycle pulse on the last cycle of each period |
| tk_reset_req | output | 1 | Registered reset request for the timekeeper |

## Verification
Any wrong value in the counter, the stretch flag or the accumulator appears at `tick` as a period of the wrong length. The bench measures every interval between ticks against a closed-form floor expression, so the error is seen at the first tick that follows it. A phase error that only shifts where the long periods fall is caught in the same way. A wrong long-period total is caught when the window closes, which is at most D periods later. A wrong enable-clear or a wrong boundary load shows up within the first two periods after the control change.

// File: rtl/tickdiv_pkg.sv
package tickdiv_pkg;

    localparam int CTRL_W   = 22;
    localparam int NDIV_W   = 9;
    localparam int FRAC_W   = 10;
    localparam int ACC_W    = 11;
    localparam int CNT_W    = NDIV_W + 1;

    localparam int FRAC_LSB = 0;
    localparam int NDIV_LSB = FRAC_LSB + FRAC_W;
    localparam int DSEL_BIT = NDIV_LSB + NDIV_W;
    localparam int EN_BIT   = DSEL_BIT + 1;
    localparam int REQ_BIT  = EN_BIT + 1;

    localparam logic [ACC_W-1:0] WIN_DEC = ACC_W'(1000);
    localparam logic [ACC_W-1:0] WIN_BIN = ACC_W'(1024);
    localparam logic [NDIV_W-1:0] NDIV_MIN = NDIV_W'(2);

    typedef struct packed {
        logic              req;
        logic              en;
        logic              dsel;
        logic [NDIV_W-1:0] ndiv;
        logic [FRAC_W-1:0] frac;
    } tick_cfg_t;

    function automatic tick_cfg_t decode_word(input logic [CTRL_W-1:0] w);
        tick_cfg_t c;
        c.req  = w[REQ_BIT];
        c.en   = w[EN_BIT];
        c.dsel = w[DSEL_BIT];
        c.ndiv = w[NDIV_LSB +: NDIV_W];
        c.frac = w[FRAC_LSB +: FRAC_W];
        return c;
    endfunction

    function automatic logic [ACC_W-1:0] window_len(input logic dsel);
        return dsel ? WIN_BIN : WIN_DEC;
    endfunction

    function automatic logic [FRAC_W-1:0] eff_frac(input tick_cfg_t c);
        logic [ACC_W-1:0] den;
        logic [ACC_W-1:0] lim;
        den = window_len(c.dsel);
        lim = den - ACC_W'(1);
        if (ACC_W'(c.frac) >= den)
            return lim[FRAC_W-1:0];
        return c.frac;
    endfunction

    function automatic logic runnable(input tick_cfg_t c);
        return c.en && (c.ndiv >= NDIV_MIN);
    endfunction

endpackage

// File: rtl/tickdiv_cfg_hold.sv
module tickdiv_cfg_hold
    import tickdiv_pkg::*;
#(
    parameter logic [CTRL_W-1:0] RESET_WORD = CTRL_W'(335528)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] word_in,
    input  logic              load,
    output tick_cfg_t         act,
    output logic              req_q
);
    localparam tick_cfg_t CFG_RST = decode_word(RESET_WORD);

    tick_cfg_t cfg_in;
    assign cfg_in = decode_word(word_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= CFG_RST;
        end else if (load) begin
            act <= cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= CFG_RST.req;
        end else begin
            req_q <= cfg_in.req;
        end
    end
endmodule

// File: rtl/tickdiv_phase.sv
module tickdiv_phase
    import tickdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    input  logic [ACC_W-1:0]  den,
    output logic              stretch
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;
    logic [ACC_W:0]   den_ext;
    logic             wrap;

    assign sum     = {1'b0, acc_q} + (ACC_W+1)'(frac);
    assign den_ext = {1'b0, den};
    assign wrap    = (sum >= den_ext);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q   <= '0;
            stretch <= 1'b0;
        end else if (step) begin
            if (wrap) begin
                acc_q <= ACC_W'(sum - den_ext);
            end else begin
                acc_q <= sum[ACC_W-1:0];
            end
            stretch <= wrap;
        end
    end
endmodule

// File: rtl/tickdiv_period_cnt.sv
module tickdiv_period_cnt
    import tickdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              kill,
    input  logic [NDIV_W-1:0] ndiv,
    input  logic              stretch,
    output logic              last
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len;

    assign len  = CNT_W'(ndiv) + CNT_W'(stretch);
    assign last = run && (cnt_q == len - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || kill || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/frac_tick_div.sv
module frac_tick_div
    import tickdiv_pkg::*;
#(
    parameter logic [CTRL_W-1:0] RESET_WORD = CTRL_W'(335528)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              tick,
    output logic              tk_reset_req
);
    tick_cfg_t act;
    logic      act_run;
    logic      in_en;
    logic      load;
    logic      last;
    logic      stretch;
    logic      restart;

    assign in_en   = ctrl_word[EN_BIT];
    assign act_run = runnable(act);
    assign restart = !act_run || !in_en;
    assign load    = restart || last;

    tickdiv_cfg_hold #(.RESET_WORD(RESET_WORD)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .word_in (ctrl_word),
        .load    (load),
        .act     (act),
        .req_q   (tk_reset_req)
    );

    tickdiv_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .clear   (restart),
        .step    (last),
        .frac    (eff_frac(act)),
        .den     (window_len(act.dsel)),
        .stretch (stretch)
    );

    tickdiv_period_cnt u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (act_run),
        .kill    (!in_en),
        .ndiv    (act.ndiv),
        .stretch (stretch),
        .last    (last)
    );

    assign tick = last;
endmodule

// File: rtl/tickdiv_checker.sv
module tickdiv_checker
    import tickdiv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic              tick,
    input logic              tk_reset_req,
    input logic [NDIV_W-1:0] act_ndiv,
    input logic              act_run
);
    // R2: a tick never lasts two cycles
    a_r2_single_tick: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R5: a tick only comes from a shadow divisor of at least two
    a_r5_min_divisor: assert property (@(posedge clk) disable iff (rst)
        tick |-> (act_ndiv >= NDIV_MIN));

    // R6: a tick requires the enable to have been high at the last edge
    a_r6_needs_enable: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(ctrl_word[EN_BIT]));

    // R7: the shadow divisor stays fixed inside a running period
    a_r7_hold_cfg: assert property (@(posedge clk) disable iff (rst)
        (act_run && !tick && ctrl_word[EN_BIT]) |=> $stable(act_ndiv));

    // R8: reset request follows the control bit by one cycle
    a_r8_req_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (tk_reset_req == $past(ctrl_word[REQ_BIT])));

    // R9: quiet first cycle after reset
    a_r9_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tick && !tk_reset_req));
endmodule

bind frac_tick_div tickdiv_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctrl_word    (ctrl_word),
    .tick         (tick),
    .tk_reset_req (tk_reset_req),
    .act_ndiv     (act.ndiv),
    .act_run      (act_run)
);

// File: tb/tb_frac_tick_div.sv
module tb_frac_tick_div;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [21:0] word = '0;
    logic        tick;
    logic        tk_reset_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    frac_tick_div dut (
        .clk          (clk),
        .rst          (rst),
        .ctrl_word    (word),
        .tick         (tick),
        .tk_reset_req (tk_reset_req)
    );

    function automatic logic [21:0] mk(int req, int en, int dsel, int n, int f);
        logic [21:0] w;
        w[21]    = 1'(req);
        w[20]    = 1'(en);
        w[19]    = 1'(dsel);
        w[18:10] = 9'(n);
        w[9:0]   = 10'(f);
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic next_tick(output int len);
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (!tick && len < 3000);
    endtask

    function automatic int exp_len(int n, int fe, int d, int k);
        if (k == 0) return n;
        return n + ((k * fe) / d - ((k - 1) * fe) / d);
    endfunction

    task automatic quiet_window(input int cycles, input string req);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tick) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    // R1 R2 R3 R4: full window sweep for one configuration
    task automatic run_cfg(input int n, input int f, input int dsel, input int nper);
        int d    = dsel ? 1024 : 1000;
        int fe   = (f >= d) ? d - 1 : f;
        int bad  = 0;
        int longs = 0;
        int len;
        @(negedge clk);
        word = mk(0, 0, dsel, n, f);
        @(negedge clk);
        word = mk(0, 1, dsel, n, f);
        for (int k = 0; k < nper; k++) begin
            next_tick(len);
            if (len != exp_len(n, fe, d, k)) begin
                bad++;
                check(1'b0, "R3 period length", len, exp_len(n, fe, d, k));
            end
            if (k >= 1 && k <= d && len == n + 1) longs++;
        end
        check(bad == 0, "R2 period lengths", bad, 0);
        if (nper > d) begin
            if (f >= d) check(longs == fe, "R4 clamped long count", longs, fe);
            else        check(longs == fe, "R3 long count per window", longs, fe);
        end
        @(negedge clk);
        word = mk(0, 0, dsel, n, f);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual expired expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int len;
        int part;
        repeat (3) @(negedge clk);
        check(tick == 1'b0, "R9 tick in reset", int'(tick), 0);
        rst = 1'b0;
        @(negedge clk);
        check(tick == 1'b0, "R9 tick after reset", int'(tick), 0);
        check(tk_reset_req == 1'b0, "R9 req after reset", int'(tk_reset_req), 0);

        // R9: default word decodes to 327 + 680/1000
        word = 22'd335528;
        quiet_window(20, "R9 default disabled");
        word = 22'd335528 | (22'd1 << 20);
        begin
            int bad = 0;
            for (int k = 0; k < 12; k++) begin
                next_tick(len);
                if (len != exp_len(327, 680, 1000, k)) bad++;
            end
            check(bad == 0, "R9 default ratio periods", bad, 0);
        end
        @(negedge clk);
        word = '0;

        // R1 R3 R4 sweeps
        run_cfg(2, 0,    0, 1001);
        run_cfg(3, 1,    0, 1001);
        run_cfg(3, 500,  0, 1001);
        run_cfg(2, 999,  0, 1001);
        run_cfg(4, 1023, 0, 1001);
        run_cfg(3, 1023, 1, 1025);
        run_cfg(5, 512,  1, 1025);
        run_cfg(2, 37,   1, 1025);
        run_cfg(7, 333,  0, 1001);

        // R5: divisors below two stay silent
        @(negedge clk);
        word = mk(0, 1, 0, 1, 0);
        quiet_window(60, "R5 divisor one");
        word = mk(0, 1, 1, 0, 300);
        quiet_window(60, "R5 divisor zero");
        word = '0;

        // R6: stop mid-period, then restart at zero phase
        @(negedge clk);
        word = mk(0, 1, 0, 4, 500);
        next_tick(len);
        check(len == 4, "R6 pre-stop period", len, 4);
        @(negedge clk);
        word = mk(0, 0, 0, 4, 500);
        quiet_window(30, "R6 disabled silent");
        word = mk(0, 1, 0, 4, 500);
        next_tick(len);
        check(len == 4, "R6 restart p0", len, 4);
        next_tick(len);
        check(len == 4, "R6 restart p1", len, 4);
        next_tick(len);
        check(len == 5, "R6 restart p2", len, 5);
        @(negedge clk);
        word = '0;

        // R7: change divisor mid-period
        @(negedge clk);
        word = mk(0, 1, 0, 5, 0);
        next_tick(len);
        @(negedge clk);
        @(negedge clk);
        part = 2;
        word = mk(0, 1, 0, 8, 0);
        next_tick(len);
        check(part + len == 5, "R7 current period kept", part + len, 5);
        next_tick(len);
        check(len == 8, "R7 new period", len, 8);
        next_tick(len);
        check(len == 8, "R7 new period again", len, 8);

        // R8: reset request level, running and idle
        word = mk(1, 1, 0, 8, 0);
        #1;
        check(tk_reset_req == 1'b0, "R8 req before edge", int'(tk_reset_req), 0);
        @(negedge clk);
        check(tk_reset_req == 1'b1, "R8 req running", int'(tk_reset_req), 1);
        word = mk(1, 0, 0, 8, 0);
        @(negedge clk);
        check(tk_reset_req == 1'b1, "R8 req idle", int'(tk_reset_req), 1);
        word = mk(0, 0, 0, 8, 0);
        @(negedge clk);
        check(tk_reset_req == 1'b0, "R8 req cleared", int'(tk_reset_req), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule